// File: doc/BRIEF.md
# Radio Link Hyperframe Receive Aligner

This block sits behind the 8B/10B decoder on the receive side of a baseband-to-radio fibre link. Each clock it accepts one decoded parallel word and one K flag per byte lane. It finds the start of the 4096-word hyperframe from the single sync comma. Then it follows the position of every word inside the 16-word basic frame and inside the 256-frame hyperframe.

The comma appears only once per hyperframe. For that reason the block does not lock on the first sighting. It verifies the comma's position twice before it declares lock. Once locked, it tolerates two lost commas in a row and gives up on the third. While locked, each received word is sorted one cycle later. Control words (word 0 of each basic frame) leave on a control port that carries the basic-frame index. The remaining words leave on an I/Q port. Any K character at a position where none belongs adds to a saturating error count.

Top module: `hf_rx_aligner`

## Requirements
- R1: After reset, and while reset is held, `sync_state` is 0, `locked` is 0, both valid outputs are 0 and `err_count` is 0.
- R2: A word is the sync comma only when bits [7:0] equal 0xBC and `rx_k[0]` is 1. A comma byte with K in another lane, a 0xBC byte without its K flag, or any other K character leaves the unsynced state (`sync_state` 0) unchanged. A true comma while unsynced moves `sync_state` to 1 (verifying) and places that word at word 0 of basic frame 0.
- R3: After the acquiring comma, two further commas must arrive exactly 4096 words apart. `sync_state` becomes 2 and `locked` rises in the cycle after the second of them.
- R4: While verifying, a word at the expected comma position that is not the comma returns `sync_state` to 0.
- R5: While verifying, a comma at any other position restarts verification with that comma taken as the new word 0 of basic frame 0.
- R6: While locked, three consecutive hyperframes without the comma at the expected position return `sync_state` to 0 and clear `locked`. A comma that is present clears the run of misses.
- R7: While locked, each word leaves one cycle after it is accepted. A word with in-frame index 0 goes to `ctrl_data` with `ctrl_valid` and its basic-frame index on `ctrl_bf_idx`. Indices 1 to 15 go to `iq_data` with `iq_valid`. No valid is raised for a word accepted while not locked.
- R8: The word at word 0 of basic frame 0 is never forwarded on either output, so `ctrl_bf_idx` is never 0 when `ctrl_valid` is 1.
- R9: While locked, a word at any position other than the expected comma position that has any K flag set increments `err_count` by one, saturating at 2^ERR_W-1. A misplaced comma is counted this way and does not move the alignment. K flags seen while unsynced or verifying are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | WORD_W | Decoded word, byte lane 0 in bits [7:0] |
| rx_k | input | WORD_W/8 | K flag per byte lane |
| iq_valid | output | 1 | `iq_data` holds an I/Q word |
| iq_data | output | WORD_W | Forwarded I/Q word |
| ctrl_valid | output | 1 | `ctrl_data` holds a control word |
| ctrl_data | output | WORD_W | Forwarded control word |
| ctrl_bf_idx | output | log2(BF_PER_HF) | Basic-frame index of the control word |
| sync_state | output | 2 | 0 unsynced, 1 verifying, 2 locked |
| locked | output | 1 | Alignment is confirmed |
| err_count | output | ERR_W | Saturating count of misplaced K characters |

## Verification
If the word counter slips while the block is locked, the slip shows on the ports within 16 cycles: `ctrl_valid` pulses on the wrong words or `ctrl_bf_idx` carries the wrong frame. A wrong hit or miss count in the sync state machine stays hidden until the next expected comma position. It then appears as `locked` changing one hyperframe (4096 cycles) early or late. For that reason the reference model is compared against every output on every cycle, across whole hyperframes. The comma patterns are chosen so that off-by-one counts in either counter change the hyperframe in which `locked` moves.

// File: rtl/hf_align_pkg.sv
package hf_align_pkg;

    typedef enum logic [1:0] {
        ST_UNSYNC = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_e;

    // K28.5 data byte as seen after decoding
    localparam logic [7:0] COMMA_K28_5 = 8'hBC;

endpackage

// File: rtl/hf_comma_detect.sv
module hf_comma_detect #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0]   rx_data,
    input  logic [WORD_W/8-1:0] rx_k,
    output logic                is_comma,
    output logic                any_k
);
    import hf_align_pkg::*;

    localparam int LANES = WORD_W / 8;

    logic [LANES-1:0] lane_k;

    // one K detector per byte lane; only lane 0 may carry the sync comma
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_k[i] = rx_k[i];
    end

    always_comb begin
        is_comma = rx_k[0] && (rx_data[7:0] == COMMA_K28_5);
        any_k    = |lane_k;
    end

endmodule

// File: rtl/hf_pos_counter.sv
module hf_pos_counter #(
    parameter int WORDS_PER_BF = 16,
    parameter int BF_PER_HF    = 256,
    parameter int WIDX_W       = $clog2(WORDS_PER_BF),
    parameter int BIDX_W       = $clog2(BF_PER_HF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    output logic [WIDX_W-1:0] word_idx,
    output logic [BIDX_W-1:0] bf_idx,
    output logic              at_start
);
    localparam logic [WIDX_W-1:0] W_LAST = WIDX_W'(WORDS_PER_BF - 1);
    localparam logic [BIDX_W-1:0] B_LAST = BIDX_W'(BF_PER_HF - 1);

    typedef struct packed {
        logic [WIDX_W-1:0] w;
        logic [BIDX_W-1:0] b;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (load) begin
            // the loading word is position 0/0, so the next one is word 1
            pos_d.w = WIDX_W'(1);
            pos_d.b = '0;
        end else if (pos_q.w == W_LAST) begin
            pos_d.w = '0;
            pos_d.b = (pos_q.b == B_LAST) ? '0 : pos_q.b + 1'b1;
        end else begin
            pos_d.w = pos_q.w + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign word_idx = pos_q.w;
    assign bf_idx   = pos_q.b;
    assign at_start = (pos_q.w == '0) && (pos_q.b == '0);

endmodule

// File: rtl/hf_sync_fsm.sv
module hf_sync_fsm #(
    parameter int LOCK_HITS   = 2,
    parameter int LOSS_MISSES = 3,
    parameter int ERR_W       = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      is_comma,
    input  logic                      any_k,
    input  logic                      at_start,
    output hf_align_pkg::sync_state_e state,
    output logic                      load,
    output logic [ERR_W-1:0]          err_count
);
    import hf_align_pkg::*;

    localparam int HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(LOSS_MISSES + 1);
    localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_MISSES - 1);

    typedef struct packed {
        sync_state_e       st;
        logic [HIT_W-1:0]  hits;
        logic [MISS_W-1:0] miss;
        logic [ERR_W-1:0]  err;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d  = f_q;
        load = 1'b0;
        unique case (f_q.st)
            ST_UNSYNC: begin
                if (is_comma) begin
                    load     = 1'b1;
                    f_d.st   = ST_VERIFY;
                    f_d.hits = '0;
                end
            end
            ST_VERIFY: begin
                if (at_start) begin
                    if (is_comma) begin
                        if (f_q.hits == HIT_LAST) begin
                            f_d.st   = ST_LOCKED;
                            f_d.miss = '0;
                        end else begin
                            f_d.hits = f_q.hits + 1'b1;
                        end
                    end else begin
                        f_d.st = ST_UNSYNC;
                    end
                end else if (is_comma) begin
                    // comma off position: restart from this one
                    load     = 1'b1;
                    f_d.hits = '0;
                end
            end
            ST_LOCKED: begin
                if (at_start) begin
                    if (is_comma) begin
                        f_d.miss = '0;
                    end else if (f_q.miss == MISS_LAST) begin
                        f_d.st = ST_UNSYNC;
                    end else begin
                        f_d.miss = f_q.miss + 1'b1;
                    end
                end else if (any_k && (f_q.err != '1)) begin
                    f_d.err = f_q.err + 1'b1;
                end
            end
            default: f_d.st = ST_UNSYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st   <= ST_UNSYNC;
            f_q.hits <= '0;
            f_q.miss <= '0;
            f_q.err  <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state     = f_q.st;
    assign err_count = f_q.err;

endmodule

// File: rtl/hf_rx_aligner.sv
module hf_rx_aligner #(
    parameter int WORD_W       = 16,
    parameter int WORDS_PER_BF = 16,
    parameter int BF_PER_HF    = 256,
    parameter int LOCK_HITS    = 2,
    parameter int LOSS_MISSES  = 3,
    parameter int ERR_W        = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W-1:0]             rx_data,
    input  logic [WORD_W/8-1:0]           rx_k,
    output logic                          iq_valid,
    output logic [WORD_W-1:0]             iq_data,
    output logic                          ctrl_valid,
    output logic [WORD_W-1:0]             ctrl_data,
    output logic [$clog2(BF_PER_HF)-1:0]  ctrl_bf_idx,
    output logic [1:0]                    sync_state,
    output logic                          locked,
    output logic [ERR_W-1:0]              err_count
);
    import hf_align_pkg::*;

    localparam int WIDX_W = $clog2(WORDS_PER_BF);
    localparam int BIDX_W = $clog2(BF_PER_HF);

    logic              is_comma;
    logic              any_k;
    logic              load;
    logic              at_start;
    logic [WIDX_W-1:0] word_idx;
    logic [BIDX_W-1:0] bf_idx;
    sync_state_e       st;

    hf_comma_detect #(.WORD_W(WORD_W)) u_det (
        .rx_data  (rx_data),
        .rx_k     (rx_k),
        .is_comma (is_comma),
        .any_k    (any_k)
    );

    hf_pos_counter #(
        .WORDS_PER_BF (WORDS_PER_BF),
        .BF_PER_HF    (BF_PER_HF)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .word_idx (word_idx),
        .bf_idx   (bf_idx),
        .at_start (at_start)
    );

    hf_sync_fsm #(
        .LOCK_HITS   (LOCK_HITS),
        .LOSS_MISSES (LOSS_MISSES),
        .ERR_W       (ERR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_comma  (is_comma),
        .any_k     (any_k),
        .at_start  (at_start),
        .state     (st),
        .load      (load),
        .err_count (err_count)
    );

    typedef struct packed {
        logic              iq_v;
        logic [WORD_W-1:0] iq_d;
        logic              ctrl_v;
        logic [WORD_W-1:0] ctrl_d;
        logic [BIDX_W-1:0] bf;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d        = o_q;
        o_d.iq_v   = 1'b0;
        o_d.ctrl_v = 1'b0;
        if ((st == ST_LOCKED) && !at_start) begin
            if (word_idx == '0) begin
                o_d.ctrl_v = 1'b1;
                o_d.ctrl_d = rx_data;
                o_d.bf     = bf_idx;
            end else begin
                o_d.iq_v = 1'b1;
                o_d.iq_d = rx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign iq_valid    = o_q.iq_v;
    assign iq_data     = o_q.iq_d;
    assign ctrl_valid  = o_q.ctrl_v;
    assign ctrl_data   = o_q.ctrl_d;
    assign ctrl_bf_idx = o_q.bf;
    assign sync_state  = st;
    assign locked      = (st == ST_LOCKED);

endmodule

// File: rtl/hf_rx_aligner_chk.sv
module hf_rx_aligner_chk #(
    parameter int WORD_W = 16,
    parameter int ERR_W  = 8,
    parameter int BIDX_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [WORD_W-1:0]   rx_data,
    input logic [WORD_W/8-1:0] rx_k,
    input logic                iq_valid,
    input logic [WORD_W-1:0]   iq_data,
    input logic                ctrl_valid,
    input logic [WORD_W-1:0]   ctrl_data,
    input logic [BIDX_W-1:0]   ctrl_bf_idx,
    input logic [1:0]          sync_state,
    input logic                locked,
    input logic [ERR_W-1:0]    err_count
);
    logic comma_in;
    assign comma_in = rx_k[0] && (rx_data[7:0] == 8'hBC);

    // R7
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_valid || ctrl_valid) |-> $past(locked));

    // R7
    one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iq_valid && ctrl_valid));

    // R7
    iq_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> (iq_data == $past(rx_data)));

    // R7
    ctrl_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |-> (ctrl_data == $past(rx_data)));

    // R8
    no_sync_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |-> (ctrl_bf_idx != '0));

    // R3
    lock_on_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(comma_in) && ($past(sync_state) == 2'd1)));

    // R6
    unlock_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> !$past(comma_in));

    // R9
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));

    // R9
    err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> $past(locked));

endmodule

bind hf_rx_aligner hf_rx_aligner_chk #(
    .WORD_W (WORD_W),
    .ERR_W  (ERR_W),
    .BIDX_W (BIDX_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .rx_k        (rx_k),
    .iq_valid    (iq_valid),
    .iq_data     (iq_data),
    .ctrl_valid  (ctrl_valid),
    .ctrl_data   (ctrl_data),
    .ctrl_bf_idx (ctrl_bf_idx),
    .sync_state  (sync_state),
    .locked      (locked),
    .err_count   (err_count)
);

// File: tb/test_hf_rx_aligner.sv
`timescale 1ns/1ps
module test_hf_rx_aligner;

    localparam int W     = 16;
    localparam int KW    = W / 8;
    localparam int ERR_W = 8;
    localparam int HF    = 4096;
    localparam int ERR_MAX = (1 << ERR_W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  rx_data = '0;
    logic [KW-1:0] rx_k = '0;
    logic          iq_valid, ctrl_valid, locked;
    logic [W-1:0]  iq_data, ctrl_data;
    logic [7:0]    ctrl_bf_idx;
    logic [1:0]    sync_state;
    logic [ERR_W-1:0] err_count;

    hf_rx_aligner i_hf_rx_aligner (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_data     (rx_data),
        .rx_k        (rx_k),
        .iq_valid    (iq_valid),
        .iq_data     (iq_data),
        .ctrl_valid  (ctrl_valid),
        .ctrl_data   (ctrl_data),
        .ctrl_bf_idx (ctrl_bf_idx),
        .sync_state  (sync_state),
        .locked      (locked),
        .err_count   (err_count)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int seed   = 1;
    bit cmp_en = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st, m_pos, m_hits, m_miss, m_err;
    bit e_iqv, e_ctv, e_start;
    logic [W-1:0] e_iqd, e_ctd;
    int e_bf;
    bit m_comma, m_anyk, m_at0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_hits = 0; m_miss = 0; m_err = 0;
            e_iqv = 0; e_ctv = 0; e_start = 0; e_iqd = '0; e_ctd = '0; e_bf = 0;
        end else begin
            m_comma = rx_k[0] && (rx_data[7:0] == 8'hBC);
            m_anyk  = (rx_k != '0);
            m_at0   = (m_pos == 0);
            e_iqv = 0; e_ctv = 0; e_start = m_at0;
            if (m_st == 2 && !m_at0) begin
                if (m_pos % 16 == 0) begin
                    e_ctv = 1; e_ctd = rx_data; e_bf = m_pos / 16;
                end else begin
                    e_iqv = 1; e_iqd = rx_data;
                end
                if (m_anyk && m_err < ERR_MAX) m_err++;
            end
            case (m_st)
                0: if (m_comma) begin m_st = 1; m_hits = 0; m_pos = 0; end
                1: begin
                    if (m_at0) begin
                        if (m_comma) begin
                            m_hits++;
                            if (m_hits == 2) begin m_st = 2; m_miss = 0; end
                        end else m_st = 0;
                    end else if (m_comma) begin
                        m_hits = 0; m_pos = 0;
                    end
                end
                default: begin
                    if (m_at0) begin
                        if (m_comma) m_miss = 0;
                        else begin
                            m_miss++;
                            if (m_miss == 3) m_st = 0;
                        end
                    end
                end
            endcase
            m_pos = (m_pos + 1) % HF;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(sync_state == 2'(m_st), "R2 sync_state", longint'(sync_state), longint'(m_st));
            chk(locked == (m_st == 2), "R3 locked", longint'(locked), longint'(m_st == 2));
            chk(iq_valid == e_iqv, "R7 iq_valid", longint'(iq_valid), longint'(e_iqv));
            if (e_iqv) chk(iq_data == e_iqd, "R7 iq_data", longint'(iq_data), longint'(e_iqd));
            if (e_start) chk(ctrl_valid == e_ctv, "R8 ctrl_valid", longint'(ctrl_valid), longint'(e_ctv));
            else         chk(ctrl_valid == e_ctv, "R7 ctrl_valid", longint'(ctrl_valid), longint'(e_ctv));
            if (e_ctv) begin
                chk(ctrl_data == e_ctd, "R7 ctrl_data", longint'(ctrl_data), longint'(e_ctd));
                chk(longint'(ctrl_bf_idx) == longint'(e_bf), "R7 ctrl_bf_idx", longint'(ctrl_bf_idx), longint'(e_bf));
            end
            chk(longint'(err_count) == longint'(m_err), "R9 err_count", longint'(err_count), longint'(m_err));
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below 190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic [W-1:0] d, input logic [KW-1:0] k);
        @(negedge clk);
        rx_data = d;
        rx_k    = k;
    endtask

    function automatic logic [W-1:0] pattern(input int p);
        return W'(seed * 40503 + p * 7);
    endfunction

    task automatic send_hf(input bit with_comma, input int kerr, input int nwords);
        int left = kerr;
        for (int p = 0; p < nwords; p++) begin
            if (p == 0) begin
                if (with_comma) drive(16'h5ABC, 2'b01);
                else            drive(16'h5A3C, 2'b00);
            end else if (left > 0 && (p % 16) != 0) begin
                // first error is a misplaced comma, the rest K28.0
                drive((left == kerr) ? 16'h00BC : 16'h001C, 2'b01);
                left--;
            end else begin
                drive(pattern(p), 2'b00);
            end
        end
        seed++;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sync_state == 2'd0, "R1 sync_state", longint'(sync_state), 0);
        chk(locked == 1'b0, "R1 locked", longint'(locked), 0);
        chk(iq_valid == 1'b0 && ctrl_valid == 1'b0, "R1 valids", longint'({iq_valid, ctrl_valid}), 0);
        chk(err_count == '0, "R1 err_count", longint'(err_count), 0);
        rst_n  = 1'b1;
        cmp_en = 1'b1;

        // R2: near-commas and other K characters keep the unsynced state
        for (int i = 0; i < 300; i++) begin
            case (i % 4)
                0: drive(16'h12BC, 2'b00);
                1: drive(16'h001C, 2'b01);
                2: drive(16'hBC00, 2'b10);
                default: drive(pattern(i), 2'b00);
            endcase
        end
        drive(16'h0000, 2'b00);
        chk(sync_state == 2'd0, "R2 stays unsynced", longint'(sync_state), 0);
        chk(err_count == '0, "R9 no count when unsynced", longint'(err_count), 0);

        // R2/R3: acquire, verify, lock
        send_hf(1'b1, 0, HF);
        chk(sync_state == 2'd1, "R2 verifying after comma", longint'(sync_state), 1);
        send_hf(1'b1, 0, HF);
        chk(locked == 1'b0, "R3 not yet locked after one confirmation", longint'(locked), 0);
        send_hf(1'b1, 0, HF);
        chk(locked == 1'b1, "R3 locked after two confirmations", longint'(locked), 1);

        // R9: misplaced comma and K28.0 while locked
        send_hf(1'b1, 3, HF);
        chk(longint'(err_count) == 3, "R9 three misplaced K", longint'(err_count), 3);
        chk(locked == 1'b1, "R9 misplaced comma keeps lock", longint'(locked), 1);

        // R6: miss tolerance and miss-run reset
        send_hf(1'b0, 0, HF);
        chk(locked == 1'b1, "R6 one miss tolerated", longint'(locked), 1);
        send_hf(1'b1, 0, HF);
        send_hf(1'b0, 0, HF);
        send_hf(1'b0, 0, HF);
        chk(locked == 1'b1, "R6 comma cleared miss run", longint'(locked), 1);
        send_hf(1'b0, 0, HF);
        chk(sync_state == 2'd0, "R6 third miss drops lock", longint'(sync_state), 0);

        // R4: failed verification
        send_hf(1'b1, 0, HF);
        send_hf(1'b0, 0, HF);
        chk(sync_state == 2'd0, "R4 verify failure", longint'(sync_state), 0);

        // R5: restart on an off-position comma during verification
        send_hf(1'b1, 0, 1000);
        send_hf(1'b1, 0, HF);
        send_hf(1'b1, 0, HF);
        send_hf(1'b1, 0, HF);
        chk(locked == 1'b1, "R5 locked on restarted alignment", longint'(locked), 1);

        // R9: saturation
        send_hf(1'b1, 300, HF);
        chk(longint'(err_count) == longint'(ERR_MAX), "R9 saturation", longint'(err_count), longint'(ERR_MAX));

        // R1: reset while locked
        @(negedge clk);
        cmp_en = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        chk(locked == 1'b0 && sync_state == 2'd0, "R1 reset clears lock", longint'(sync_state), 0);
        chk(err_count == '0, "R1 reset clears err_count", longint'(err_count), 0);
        chk(iq_valid == 1'b0 && ctrl_valid == 1'b0, "R1 reset clears valids", longint'({iq_valid, ctrl_valid}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule